// File: doc/BRIEF.md
# Single-Port Memory FIFO

This block is a first-in first-out queue whose storage is a single synchronous memory with only one access port. Each clock cycle it performs at most one operation: an enqueue or a dequeue, never both. A valid strobe says an operation is requested, and a direction bit says which one.

An enqueue writes the input word at the tail. A dequeue starts a registered memory read, so the head word shows up on the data output one cycle after the request. That output then holds its value until the next accepted dequeue.

Occupancy is tracked by two wrapping pointers and a one-bit record of whether the last accepted operation removed an entry. Equal pointers mean empty when that record says remove, and full when it says insert. The full and empty flags are decoded from this state without extra registers. A requester is expected to watch the flags. A request that the flags forbid is dropped without effect.

Top module: `spfifo`

## Requirements
- R1: A synchronous active-high reset leaves the queue holding no entries, with `empty` = 1 and `full` = 0 in the cycle after reset is released, whatever was stored before.
- R2: Words leave in the order they entered. After a clock edge that accepts a dequeue (`req_valid` = 1, `req_push` = 0, `empty` = 0), `rd_data` carries the oldest stored word from that edge onward.
- R3: `empty` is 1 exactly when the number of stored entries is zero.
- R4: `full` is 1 exactly when the number of stored entries equals `DEPTH`.
- R5: `full` and `empty` are never 1 in the same cycle.
- R6: An enqueue request while `full` = 1, or a dequeue request while `empty` = 1, is ignored. It changes neither the stored contents nor the flags, and a dequeue ignored this way leaves `rd_data` unchanged.
- R7: While `req_valid` = 0, the value of `req_push` has no effect on the contents, the flags or `rd_data`.
- R8: Both pointers wrap from `DEPTH`-1 back to entry 0 even when `DEPTH` is not a power of two, so order and occupancy stay correct over many laps of the storage.
- R9: `rd_data` changes only on a clock edge that accepts a dequeue, and otherwise holds the last word dequeued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An operation is requested this cycle |
| req_push | input | 1 | 1 selects enqueue, 0 selects dequeue |
| wr_data | input | WIDTH | Word to enqueue |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| rd_data | output | WIDTH | Most recently dequeued word |

## Verification
The case of interest is a request that lands in the same cycle as the flag that forbids it. One form is an enqueue on the cycle `full` rises. The other is a dequeue on the cycle the last entry leaves. The bench sets these up on purpose by filling and draining the queue to its edges. It also reaches them by accident in a long pseudo-random run, where requests are issued without looking at the flags. A queue model in the bench accepts or drops each request from its own occupancy count. It is compared against the flags and `rd_data` every cycle, so an illegal request that leaks into the pointers, the direction bit or the read register shows up as a mismatch.

// File: rtl/spfifo.sv
module spfifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_push,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             empty,
  output logic [WIDTH-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0]    rptr, wptr;
  logic             last_rd;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;
  logic             same, do_push, do_pop;

  assign same    = (rptr == wptr);
  assign empty   = same && last_rd;
  assign full    = same && !last_rd;
  assign do_push = req_valid && req_push && !full;
  assign do_pop  = req_valid && !req_push && !empty;
  assign rd_data = rd_q;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr    <= '0;
      wptr    <= '0;
      last_rd <= 1'b1;
    end else begin
      if (do_push) wptr <= step_ptr(wptr);
      if (do_pop)  rptr <= step_ptr(rptr);
      if (do_push)     last_rd <= 1'b0;
      else if (do_pop) last_rd <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)     mem[wptr] <= wr_data;
    else if (do_pop) rd_q      <= mem[rptr];
  end

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full));

  assert_never_both_R5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_push_fills_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_push && !full) |=> !empty);

  assert_pop_drains_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push && !empty) |=> !full);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_push && full) |=> (full && $stable(rd_data)));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push && empty) |=> (empty && $stable(rd_data)));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(full) && $stable(empty) && $stable(rd_data)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_push) |=> $stable(rd_data));
endmodule

// File: tb/tb_spfifo.sv
`timescale 1ns/1ps
module tb_spfifo;
  localparam int WIDTH = 16;
  localparam int DEPTH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_push = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic full, empty;
  logic [WIDTH-1:0] rd_data;

  spfifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_push(req_push),
    .wr_data(wr_data), .full(full), .empty(empty), .rd_data(rd_data));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] exp_rd = '0;
  bit rd_known = 0;
  int unsigned lcg = 32'h1234_5678;
  logic [WIDTH-1:0] tag_ctr = 16'h0100;

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string tflag, string tdata);
    check(tflag == "" ? "R3" : tflag, WIDTH'(empty), WIDTH'(q.size() == 0));
    check(tflag == "" ? "R4" : tflag, WIDTH'(full),  WIDTH'(q.size() == DEPTH));
    check("R5", WIDTH'(full && empty), '0);
    if (rd_known) check(tdata, rd_data, exp_rd);
  endtask

  task automatic step(bit v, bit push, logic [WIDTH-1:0] d, string tflag, string tdata);
    req_valid = v; req_push = push; wr_data = d;
    @(posedge clk);
    if (v && push && q.size() < DEPTH) q.push_back(d);
    else if (v && !push && q.size() > 0) begin
      exp_rd = q.pop_front();
      rd_known = 1;
    end
    @(negedge clk);
    compare(tflag, tdata);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    @(negedge clk);
    check("R1", WIDTH'(empty), 1);
    check("R1", WIDTH'(full), 0);
  endtask

  function automatic logic [WIDTH-1:0] nextd();
    tag_ctr = tag_ctr + 16'h0013;
    return tag_ctr;
  endfunction

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // fill to capacity: R3 then R4
    for (int i = 0; i < DEPTH; i++) step(1, 1, nextd(), "", "R2");
    // enqueue while full is dropped (R6)
    step(1, 1, 16'hDEAD, "R6", "R6");
    step(1, 1, 16'hBEEF, "R6", "R6");
    // idle with both direction values (R7)
    step(0, 1, 16'hAAAA, "R7", "R7");
    step(0, 0, 16'hBBBB, "R7", "R7");
    // drain in order (R2)
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0, "", "R2");
    // dequeue while empty is dropped, rd_data held (R6)
    step(1, 0, '0, "R6", "R6");
    step(1, 0, '0, "R6", "R6");
    // idle holds last dequeued word (R9)
    step(0, 0, '0, "", "R9");
    step(1, 1, nextd(), "", "R9");
    step(0, 1, '0, "R7", "R9");
    step(1, 0, '0, "", "R2");

    // many laps around a non-power-of-two depth (R8)
    for (int lap = 0; lap < 40; lap++) begin
      step(1, 1, nextd(), "R8", "R8");
      step(1, 1, nextd(), "R8", "R8");
      step(1, 0, '0, "R8", "R8");
    end
    for (int i = 0; i < 3 * DEPTH; i++) step(1, 0, '0, "R8", "R8");

    // mixed traffic that ignores the flags
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[28:26] != 3'd0, lcg[30] ^ (i[7] & lcg[20]), lcg[15:0], "", "R2");
    end

    // reset with data inside (R1)
    step(1, 1, nextd(), "", "R2");
    do_reset();
    step(1, 0, '0, "R6", "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule